// File: doc/BRIEF.md
# Repeated-Primitive Run Compressor

This block sits in the transmit path of a serial link layer, just ahead of the line encoder. Each clock it accepts one 32-bit dword with a flag that marks it as a control primitive or as payload. A primitive repeated many times in a row is shortened on the wire. The first two copies are forwarded as they are. The third copy is replaced by a CONT primitive. Every further copy becomes a filler dword until the run ends. The far end treats filler as "same primitive still in force".

Filler normally comes from an external scrambler, which presents a fresh word every cycle on `scr_word`. For debugging, `junk_sel` replaces the filler with the constant 32'hDEADBEEF. Clearing `cont_en` switches compression off, and raw repeats are then sent. ALIGN primitives are handled separately by another block. They are never compressed, and they may be inserted in the middle of a run without breaking it. The output is registered, so there is one cycle of latency.

Top module: `cont_compressor`

## Requirements
- R1: The output is registered with one cycle of latency. While reset is held, `out_word` is zero and `out_is_prim` is low.
- R2: When `cont_en` is high, the first and second consecutive copies of a non-ALIGN primitive are forwarded unchanged, with `out_is_prim` high.
- R3: When `cont_en` is high, the third consecutive copy is replaced by the CONT primitive (default 32'h9999AA7C), with `out_is_prim` high.
- R4: The fourth and later consecutive copies are each replaced by one filler dword, with `out_is_prim` low.
- R5: When `junk_sel` is low, the filler is the `scr_word` value presented in the same cycle as that input copy.
- R6: When `junk_sel` is high, the filler is 32'hDEADBEEF. `junk_sel` is sampled per dword, so it can change in the middle of a run.
- R7: A different primitive or a data dword ends the run and is forwarded unchanged. A new primitive needs two more copies before CONT is substituted again.
- R8: An ALIGN primitive (default 32'h7B4A4ABC) is always forwarded unchanged, even when repeated. It neither starts, ends nor advances a run.
- R9: When `cont_en` is low, every dword is forwarded unchanged and run tracking is cleared. After `cont_en` returns high, the next copy counts as a first occurrence.
- R10: Data dwords (`in_is_prim` low) are always forwarded unchanged with `out_is_prim` low, even when their value equals a primitive code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 32 | Incoming dword |
| in_is_prim | input | 1 | High when `in_word` is a primitive |
| cont_en | input | 1 | Compression enable (reset value of the controlling bit is 1) |
| junk_sel | input | 1 | Select the constant debug filler instead of scrambled filler |
| scr_word | input | 32 | Current word from the external scrambler |
| out_word | output | 32 | Outgoing dword |
| out_is_prim | output | 1 | High when `out_word` is a primitive |

## Verification
Two pairs of events can land on the same dword. An ALIGN can arrive in the middle of a filler phase, and the next copy of the run must still produce filler and not restart with a raw primitive. `cont_en` can also fall on exactly the copy that would have become CONT, and the raw primitive must go out instead. The bench provokes both in its vector table and checks the output dword and flag one cycle later. A reset applied in the middle of a filler phase is checked as well: the same primitive must then restart from its first copy.

// File: rtl/cont_compressor.sv
module cont_compressor #(
  parameter int          W          = 32,
  parameter logic [31:0] CONT_WORD  = 32'h9999_AA7C,
  parameter logic [31:0] ALIGN_WORD = 32'h7B4A_4ABC,
  parameter logic [31:0] DEBUG_FILL = 32'hDEAD_BEEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_word,
  input  logic         in_is_prim,
  input  logic         cont_en,
  input  logic         junk_sel,
  input  logic [W-1:0] scr_word,
  output logic [W-1:0] out_word,
  output logic         out_is_prim
);

  logic [W-1:0] last_prim;
  logic         tracking;
  logic [1:0]   seen;

  logic is_align, repeat_hit;
  logic [W-1:0] filler;

  assign is_align   = in_is_prim && (in_word == W'(ALIGN_WORD));
  assign repeat_hit = cont_en && in_is_prim && !is_align && tracking && (in_word == last_prim);
  assign filler     = junk_sel ? W'(DEBUG_FILL) : scr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_prim <= '0;
      tracking  <= 1'b0;
      seen      <= 2'd0;
    end else if (!cont_en) begin
      tracking  <= 1'b0;
      seen      <= 2'd0;
    end else if (is_align) begin
      tracking  <= tracking;
    end else if (repeat_hit) begin
      if (seen != 2'd2) seen <= seen + 2'd1;
    end else if (in_is_prim) begin
      last_prim <= in_word;
      tracking  <= 1'b1;
      seen      <= 2'd0;
    end else begin
      tracking  <= 1'b0;
      seen      <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word    <= '0;
      out_is_prim <= 1'b0;
    end else if (repeat_hit && seen == 2'd1) begin
      out_word    <= W'(CONT_WORD);
      out_is_prim <= 1'b1;
    end else if (repeat_hit && seen == 2'd2) begin
      out_word    <= filler;
      out_is_prim <= 1'b0;
    end else begin
      out_word    <= in_word;
      out_is_prim <= in_is_prim;
    end
  end

endmodule

// File: rtl/cont_compressor_chk.sv
module cont_compressor_chk #(
  parameter int          W          = 32,
  parameter logic [31:0] CONT_WORD  = 32'h9999_AA7C,
  parameter logic [31:0] ALIGN_WORD = 32'h7B4A_4ABC,
  parameter logic [31:0] DEBUG_FILL = 32'hDEAD_BEEF
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] in_word,
  input logic         in_is_prim,
  input logic         cont_en,
  input logic         junk_sel,
  input logic [W-1:0] scr_word,
  input logic [W-1:0] out_word,
  input logic         out_is_prim
);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (out_word == '0 && !out_is_prim));

  p_data_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !in_is_prim) |=> (out_word == $past(in_word) && !out_is_prim));

  p_align_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && in_is_prim && in_word == W'(ALIGN_WORD)) |=>
      (out_word == W'(ALIGN_WORD) && out_is_prim));

  p_raw_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !cont_en) |=> (out_word == $past(in_word) && out_is_prim == $past(in_is_prim)));

  p_filler_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && $past(in_is_prim) && !out_is_prim) |->
      (out_word == ($past(junk_sel) ? W'(DEBUG_FILL) : $past(scr_word))));

  p_prim_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && out_is_prim) |-> $past(in_is_prim));

  p_new_prim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_is_prim) && $past(in_word) != W'(ALIGN_WORD)
      && $past(in_word, 2) != W'(ALIGN_WORD) && $past(in_word, 2) != $past(in_word))
      |-> (out_word == $past(in_word) && out_is_prim));

endmodule

bind cont_compressor cont_compressor_chk #(
  .W(W), .CONT_WORD(CONT_WORD), .ALIGN_WORD(ALIGN_WORD), .DEBUG_FILL(DEBUG_FILL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_is_prim(in_is_prim),
  .cont_en(cont_en), .junk_sel(junk_sel), .scr_word(scr_word),
  .out_word(out_word), .out_is_prim(out_is_prim)
);

// File: tb/cont_compressor_test.sv
`timescale 1ns/1ps
module cont_compressor_test;

  localparam logic [31:0] CONT  = 32'h9999_AA7C;
  localparam logic [31:0] ALIGN = 32'h7B4A_4ABC;
  localparam logic [31:0] SYNC  = 32'hB5B5_957C;
  localparam logic [31:0] HOLD  = 32'hD5D5_AA7C;
  localparam logic [31:0] BEEF  = 32'hDEAD_BEEF;
  localparam int NV = 24;

  // {prim, word, cont_en, junk_sel, scr, exp_prim, exp_word}
  localparam logic [99:0] VEC [NV] = '{
    {1'b0, 32'h1111_1111, 1'b1, 1'b0, 32'h0000_00A0, 1'b0, 32'h1111_1111}, // R10
    {1'b1, SYNC,          1'b1, 1'b0, 32'h0000_00A1, 1'b1, SYNC},          // R2
    {1'b1, SYNC,          1'b1, 1'b0, 32'h0000_00A2, 1'b1, SYNC},          // R2
    {1'b1, SYNC,          1'b1, 1'b0, 32'h0000_00A3, 1'b1, CONT},          // R3
    {1'b1, SYNC,          1'b1, 1'b0, 32'hC0FF_EE01, 1'b0, 32'hC0FF_EE01}, // R4 R5
    {1'b1, SYNC,          1'b1, 1'b0, 32'hC0FF_EE02, 1'b0, 32'hC0FF_EE02}, // R5
    {1'b1, ALIGN,         1'b1, 1'b0, 32'hC0FF_EE03, 1'b1, ALIGN},         // R8
    {1'b1, SYNC,          1'b1, 1'b0, 32'hC0FF_EE04, 1'b0, 32'hC0FF_EE04}, // R8
    {1'b1, SYNC,          1'b1, 1'b1, 32'hC0FF_EE05, 1'b0, BEEF},          // R6
    {1'b1, HOLD,          1'b1, 1'b1, 32'h0000_00B0, 1'b1, HOLD},          // R7
    {1'b1, HOLD,          1'b1, 1'b1, 32'h0000_00B1, 1'b1, HOLD},          // R7
    {1'b1, HOLD,          1'b1, 1'b1, 32'h0000_00B2, 1'b1, CONT},          // R3
    {1'b1, HOLD,          1'b1, 1'b1, 32'h0000_00B3, 1'b0, BEEF},          // R6
    {1'b0, 32'h2222_2222, 1'b1, 1'b0, 32'h0000_00B4, 1'b0, 32'h2222_2222}, // R7
    {1'b1, HOLD,          1'b1, 1'b0, 32'h0000_00B5, 1'b1, HOLD},          // R7
    {1'b1, HOLD,          1'b1, 1'b0, 32'h0000_00B6, 1'b1, HOLD},          // R7
    {1'b1, HOLD,          1'b0, 1'b0, 32'h0000_00B7, 1'b1, HOLD},          // R9
    {1'b1, HOLD,          1'b0, 1'b0, 32'h0000_00B8, 1'b1, HOLD},          // R9
    {1'b1, HOLD,          1'b1, 1'b0, 32'h0000_00B9, 1'b1, HOLD},          // R9
    {1'b1, HOLD,          1'b1, 1'b0, 32'h0000_00BA, 1'b1, HOLD},          // R9
    {1'b0, CONT,          1'b1, 1'b0, 32'h0000_00BB, 1'b0, CONT},          // R10
    {1'b1, ALIGN,         1'b1, 1'b0, 32'h0000_00BC, 1'b1, ALIGN},         // R8
    {1'b1, ALIGN,         1'b1, 1'b0, 32'h0000_00BD, 1'b1, ALIGN},         // R8
    {1'b1, ALIGN,         1'b1, 1'b0, 32'h0000_00BE, 1'b1, ALIGN}          // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_is_prim = 1'b0;
  logic        cont_en = 1'b1;
  logic        junk_sel = 1'b0;
  logic [31:0] scr_word = '0;
  logic [31:0] out_word;
  logic        out_is_prim;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cont_compressor uut (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_is_prim(in_is_prim),
    .cont_en(cont_en), .junk_sel(junk_sel), .scr_word(scr_word),
    .out_word(out_word), .out_is_prim(out_is_prim)
  );

  task automatic check(input string req, input logic ep, input logic [31:0] ew);
    checks++;
    if (out_is_prim !== ep || out_word !== ew) begin
      fails++;
      $display("FAIL %s: got prim=%0b word=%08h, expected prim=%0b word=%08h",
               req, out_is_prim, out_word, ep, ew);
    end
  endtask

  task automatic step(input logic p, input logic [31:0] w, input logic ce,
                      input logic js, input logic [31:0] s);
    in_is_prim = p; in_word = w; cont_en = ce; junk_sel = js; scr_word = s;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    in_is_prim = 1'b1; in_word = SYNC;
    @(negedge clk);
    check("R1 reset", 1'b0, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][99], VEC[i][98:67], VEC[i][66], VEC[i][65], VEC[i][64:33]);
      check($sformatf("R1 vector %0d", i), VEC[i][32], VEC[i][31:0]);
    end
    // R1 R7: reset while in filler phase, run restarts from first copy
    step(1'b1, HOLD, 1'b1, 1'b0, 32'h1);
    step(1'b1, HOLD, 1'b1, 1'b0, 32'h2);
    step(1'b1, HOLD, 1'b1, 1'b0, 32'h3);
    step(1'b1, HOLD, 1'b1, 1'b0, 32'h4);
    check("R4 filler before reset", 1'b0, 32'h4);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 1'b0, 32'h0);
    rst_n = 1'b1;
    step(1'b1, HOLD, 1'b1, 1'b0, 32'h5);
    check("R2 first after reset", 1'b1, HOLD);
    step(1'b1, HOLD, 1'b1, 1'b0, 32'h6);
    check("R2 second after reset", 1'b1, HOLD);
    // R9: cont_en falls exactly on the copy that would become CONT
    step(1'b1, HOLD, 1'b0, 1'b0, 32'h7);
    check("R9 disable on third copy", 1'b1, HOLD);
    // R7: alternating primitives never compress
    step(1'b1, SYNC, 1'b1, 1'b0, 32'h8);
    check("R7 alternate a", 1'b1, SYNC);
    step(1'b1, HOLD, 1'b1, 1'b0, 32'h9);
    check("R7 alternate b", 1'b1, HOLD);
    step(1'b1, SYNC, 1'b1, 1'b0, 32'hA);
    check("R7 alternate c", 1'b1, SYNC);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule